// File: doc/BRIEF.md
# Non-Volatile Array Margin Check Sequencer

This block runs a self-test on a small non-volatile array. For every row it reads the row once at the normal sense reference and keeps that value. It then reads the same row with the sense reference raised, which proves that the stored ones hold, and with the reference lowered, which proves that the stored zeros hold. Each margin read is compared with the normal read. The first difference ends the test at once. The outcome and the reference that failed are kept in a small control/status register.

Software starts the test by writing the start bit of the control/status register and then polls the same register. The start bit reads back as 1 while the test runs and drops to 0 by itself when the test ends. The two-bit status field shows idle, running, pass or fail. A read strobe clears a finished result back to idle. The array side drives an enable, a reference select and a row index. It takes the row data back combinationally in the same cycle. The analog reference generation sits outside this block.

Top module: `mc_margin_seq`

## Requirements
- R1: After reset, csr_rdata is 8'h00 and arr_en is 0.
- R2: A start is a write with csr_wdata bit 0 = 1 and bits 2:1 = 0 while the test is not running. From the next cycle csr_rdata reads MCI (bit 0) = 1 and MS (bits 4:3) = 2'b11 (running). Bits 2:1 and 7:6 always read 0, and MM is bit 5.
- R3: While the test runs, arr_en is 1. Rows 0 to ROWS-1 are visited in ascending order. Each row is presented for one cycle with arr_ref = 2'b00 (normal), then for one cycle with 2'b01 (raised), then for one cycle with 2'b10 (lowered).
- R4: When every margin read equals the normal read of its row, MS becomes 2'b01 (pass) and MCI becomes 0 exactly 3*ROWS cycles after the start write was taken. arr_en drops at the same time.
- R5: When a raised-reference read differs from the normal read, the test stops at once. On the next cycle MS = 2'b10 (fail), MM = 1, MCI = 0 and arr_en = 0.
- R6: When a lowered-reference read differs from the normal read, the test stops at once with MS = 2'b10 and MM = 0.
- R7: A csr_rd strobe while MS shows pass or fail sets MS to 2'b00 on the next cycle. MM is left unchanged.
- R8: A csr_rd strobe while the test runs has no effect on MS or on the sequence.
- R9: A start write while the test runs is ignored, and the test completes at its original time.
- R10: A write with bit 1 or bit 2 set does not start the test, even if bit 0 is 1.
- R11: MM keeps its value through reads and idle time. It is cleared to 0 only when a new test starts, or by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | Control/status register write strobe |
| csr_wdata | input | 8 | Write data (bit 0 start, bits 2:1 must be 0) |
| csr_rd | input | 1 | Read strobe; clears a finished status |
| csr_rdata | output | 8 | {2'b0, MM, MS[1:0], 2'b0, MCI} |
| arr_en | output | 1 | Array read enable, high while the test runs |
| arr_ref | output | 2 | Sense reference: 00 normal, 01 raised, 10 lowered |
| arr_row | output | $clog2(ROWS) | Row under test |
| arr_rdata | input | DATA_W | Row data returned in the same cycle |

## Verification
Each array read takes exactly one cycle. Step s of the sweep (row s/3, reference s%3) appears on the array port s cycles after the edge that took the start write. A mismatch at step s shows up in the status s+1 cycles after that edge, and a clean sweep ends at 3*ROWS. A read strobe changes the status one edge later. The bench keeps a step-counting model that advances on every rising edge. All outputs are compared against it on each falling edge, so every result is checked in the cycle it is due. The named checks measure the edge count from start to finish for passing runs and for runs with faults on the raised and lowered references.

// File: rtl/mc_pkg.sv
package mc_pkg;

    typedef enum logic [1:0] {
        REF_NOM  = 2'b00,
        REF_HIGH = 2'b01,
        REF_LOW  = 2'b10
    } ref_e;

    typedef enum logic [1:0] {
        MS_IDLE = 2'b00,
        MS_PASS = 2'b01,
        MS_FAIL = 2'b10,
        MS_RUN  = 2'b11
    } ms_e;

    localparam int CSR_W      = 8;
    localparam int BIT_START  = 0;
    localparam int BIT_MS_LO  = 3;
    localparam int BIT_MM     = 5;

endpackage

// File: rtl/mc_row_walker.sv
module mc_row_walker
    import mc_pkg::*;
#(
    parameter int ROWS = 8,
    localparam int AW = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic          halt,
    output logic          busy,
    output ref_e          rsel,
    output logic [AW-1:0] row,
    output logic          done
);

    localparam logic [AW-1:0] LAST = AW'(ROWS - 1);

    typedef struct packed {
        logic          busy;
        logic [AW-1:0] row;
        ref_e          rsel;
    } walk_t;

    localparam walk_t IDLE_ST = '{busy: 1'b0, row: '0, rsel: REF_NOM};

    walk_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        done = 1'b0;
        if (!st_q.busy) begin
            if (go) begin
                st_d.busy = 1'b1;
                st_d.row  = '0;
                st_d.rsel = REF_NOM;
            end
        end else if (halt) begin
            st_d = IDLE_ST;
        end else begin
            case (st_q.rsel)
                REF_NOM:  st_d.rsel = REF_HIGH;
                REF_HIGH: st_d.rsel = REF_LOW;
                REF_LOW: begin
                    if (st_q.row == LAST) begin
                        st_d = IDLE_ST;
                        done = 1'b1;
                    end else begin
                        st_d.row  = st_q.row + AW'(1);
                        st_d.rsel = REF_NOM;
                    end
                end
                default: st_d = IDLE_ST;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= IDLE_ST;
        else        st_q <= st_d;
    end

    assign busy = st_q.busy;
    assign rsel = st_q.rsel;
    assign row  = st_q.row;

    // R3: normal read is always followed by the raised read of the same row
    a_r3_nom_then_high: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.rsel == REF_NOM && !halt)
        |=> (st_q.busy && st_q.rsel == REF_HIGH && $stable(st_q.row)));

    // R3: after the lowered read of a non-final row the next row starts
    a_r3_row_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.rsel == REF_LOW && st_q.row != LAST && !halt)
        |=> (st_q.busy && st_q.rsel == REF_NOM && st_q.row == $past(st_q.row) + AW'(1)));

    // R5: a halt ends the sweep on the next edge
    a_r5_halt_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && halt) |=> !st_q.busy);

endmodule

// File: rtl/mc_compare.sv
module mc_compare
    import mc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  ref_e              rsel,
    input  logic [DATA_W-1:0] rdata,
    output logic              mis,
    output logic              mis_hi
);

    logic [DATA_W-1:0] nom_d, nom_q;

    always_comb begin
        nom_d = nom_q;
        if (busy && rsel == REF_NOM) nom_d = rdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) nom_q <= '0;
        else        nom_q <= nom_d;
    end

    assign mis    = busy && (rsel != REF_NOM) && (rdata != nom_q);
    assign mis_hi = (rsel == REF_HIGH);

endmodule

// File: rtl/mc_csr.sv
module mc_csr
    import mc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CSR_W-1:0] wdata,
    input  logic             rd,
    input  logic             mis,
    input  logic             mis_hi,
    input  logic             done,
    output logic             go,
    output logic [CSR_W-1:0] rdata
);

    typedef struct packed {
        ms_e  ms;
        logic mm;
    } csr_t;

    csr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        go   = we && wdata[BIT_START] && (wdata[2:1] == 2'b00) && (st_q.ms != MS_RUN);
        if (go) begin
            st_d.ms = MS_RUN;
            st_d.mm = 1'b0;
        end else if (st_q.ms == MS_RUN) begin
            if (mis) begin
                st_d.ms = MS_FAIL;
                st_d.mm = mis_hi;
            end else if (done) begin
                st_d.ms = MS_PASS;
            end
        end else if (rd) begin
            st_d.ms = MS_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{ms: MS_IDLE, mm: 1'b0};
        else        st_q <= st_d;
    end

    always_comb begin
        rdata                        = '0;
        rdata[BIT_START]             = (st_q.ms == MS_RUN);
        rdata[BIT_MS_LO +: 2]        = st_q.ms;
        rdata[BIT_MM]                = st_q.mm;
    end

    // R5/R6: a mismatch while running latches fail and the reference
    a_r5_fail_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ms == MS_RUN && mis) |=> (st_q.ms == MS_FAIL && st_q.mm == $past(mis_hi)));

    // R4: clean completion reports pass
    a_r4_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ms == MS_RUN && done && !mis) |=> (st_q.ms == MS_PASS));

    // R7: read clears a finished status
    a_r7_rd_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.ms == MS_PASS || st_q.ms == MS_FAIL) && rd && !go) |=> (st_q.ms == MS_IDLE));

    // R8/R9: strobes do not disturb a running test
    a_r8_run_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ms == MS_RUN && !mis && !done) |=> (st_q.ms == MS_RUN));

    // R11: MM only moves on a start or a failure
    a_r11_mm_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ms != MS_RUN && !go) |=> $stable(st_q.mm));

endmodule

// File: rtl/mc_margin_seq.sv
module mc_margin_seq
    import mc_pkg::*;
#(
    parameter int ROWS   = 8,
    parameter int DATA_W = 32,
    localparam int AW = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_we,
    input  logic [7:0]        csr_wdata,
    input  logic              csr_rd,
    output logic [7:0]        csr_rdata,
    output logic              arr_en,
    output logic [1:0]        arr_ref,
    output logic [AW-1:0]     arr_row,
    input  logic [DATA_W-1:0] arr_rdata
);

    logic go, busy, done, mis, mis_hi;
    ref_e rsel;

    mc_row_walker #(.ROWS(ROWS)) u_walk (
        .clk  (clk),
        .rst_n(rst_n),
        .go   (go),
        .halt (mis),
        .busy (busy),
        .rsel (rsel),
        .row  (arr_row),
        .done (done)
    );

    mc_compare #(.DATA_W(DATA_W)) u_cmp (
        .clk   (clk),
        .rst_n (rst_n),
        .busy  (busy),
        .rsel  (rsel),
        .rdata (arr_rdata),
        .mis   (mis),
        .mis_hi(mis_hi)
    );

    mc_csr u_csr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (csr_we),
        .wdata (csr_wdata),
        .rd    (csr_rd),
        .mis   (mis),
        .mis_hi(mis_hi),
        .done  (done),
        .go    (go),
        .rdata (csr_rdata)
    );

    assign arr_en  = busy;
    assign arr_ref = rsel;

    // R2/R3: the readable start bit and the array enable are driven by
    // separate state machines and must agree on every cycle
    a_r2_mci_matches_sweep: assert property (@(posedge clk) disable iff (!rst_n)
        csr_rdata[BIT_START] == arr_en);

    // R3: reference select never takes the unused code
    a_r3_ref_legal: assert property (@(posedge clk) disable iff (!rst_n)
        arr_en |-> (arr_ref != 2'b11));

endmodule

// File: tb/sim_mc_margin_seq.sv
module sim_mc_margin_seq;

    localparam int ROWS   = 8;
    localparam int DATA_W = 32;
    localparam int AW     = $clog2(ROWS);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              csr_we = 1'b0;
    logic [7:0]        csr_wdata = '0;
    logic              csr_rd = 1'b0;
    logic [7:0]        csr_rdata;
    logic              arr_en;
    logic [1:0]        arr_ref;
    logic [AW-1:0]     arr_row;
    logic [DATA_W-1:0] arr_rdata;

    always #2.5 clk = ~clk;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit fin = 1'b0;
    int f_hi_row = -1;
    int f_lo_row = -1;

    function automatic logic [DATA_W-1:0] arr_val(int r, int rf);
        logic [DATA_W-1:0] v;
        v = 32'hA5C3_0F96 ^ (32'(r) * 32'h0101_0101);
        if (rf == 1 && r == f_hi_row) v = v ^ 32'h0000_0400;
        if (rf == 2 && r == f_lo_row) v = v ^ 32'h0002_0000;
        return v;
    endfunction

    assign arr_rdata = arr_val(int'(arr_row), int'(arr_ref));

    mc_margin_seq #(.ROWS(ROWS), .DATA_W(DATA_W)) u0 (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_wdata(csr_wdata),
        .csr_rd(csr_rd), .csr_rdata(csr_rdata), .arr_en(arr_en),
        .arr_ref(arr_ref), .arr_row(arr_row), .arr_rdata(arr_rdata)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // reference model: step counter over 3*ROWS reads
    bit m_run = 1'b0;
    int m_step = 0;
    int m_ms = 0;
    bit m_mm = 1'b0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            m_run = 1'b0; m_step = 0; m_ms = 0; m_mm = 1'b0;
        end else if (m_run) begin
            int r, rf;
            r  = m_step / 3;
            rf = m_step % 3;
            if (rf != 0 && arr_val(r, rf) != arr_val(r, 0)) begin
                m_run = 1'b0; m_ms = 2; m_mm = (rf == 1);
            end else if (m_step == 3 * ROWS - 1) begin
                m_run = 1'b0; m_ms = 1;
            end else begin
                m_step++;
            end
        end else if (csr_we && csr_wdata[0] && csr_wdata[2:1] == 2'b00) begin
            m_run = 1'b1; m_step = 0; m_ms = 3; m_mm = 1'b0;
        end else if (csr_rd && (m_ms == 1 || m_ms == 2)) begin
            m_ms = 0;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !fin) begin
            chk("R2 csr_rdata vs model", 32'(csr_rdata),
                32'({2'b00, m_mm, 2'(m_ms), 2'b00, m_run}));
            chk("R3 arr_en vs model", 32'(arr_en), 32'(m_run));
            if (m_run) begin
                chk("R3 arr_row vs model", 32'(arr_row), 32'(m_step / 3));
                chk("R3 arr_ref vs model", 32'(arr_ref), 32'(m_step % 3));
            end
        end
    end

    task automatic wr(logic [7:0] v);
        @(negedge clk); csr_we = 1'b1; csr_wdata = v;
        @(negedge clk); csr_we = 1'b0; csr_wdata = '0;
    endtask

    task automatic rd();
        @(negedge clk); csr_rd = 1'b1;
        @(negedge clk); csr_rd = 1'b0;
    endtask

    // waits for MCI to drop, returns edges since start edge
    task automatic wait_end(int t0, output int n);
        while (csr_rdata[0]) @(negedge clk);
        n = cyc - t0;
    endtask

    task automatic finish_run();
        fin = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int t0, n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 rdata after reset", 32'(csr_rdata), 32'h00);
        chk("R1 arr_en after reset", 32'(arr_en), 32'h0);

        // R2, R4: clean pass
        wr(8'h01); t0 = cyc;
        chk("R2 MCI set", 32'(csr_rdata[0]), 32'h1);
        chk("R2 MS running", 32'(csr_rdata[4:3]), 32'h3);
        wait_end(t0, n);
        chk("R4 pass latency", 32'(n), 32'(3 * ROWS));
        chk("R4 MS pass", 32'(csr_rdata[4:3]), 32'h1);
        chk("R4 arr_en low", 32'(arr_en), 32'h0);
        // R7: read clears
        rd();
        chk("R7 MS cleared", 32'(csr_rdata[4:3]), 32'h0);

        // R8, R9: strobes during run
        wr(8'h01); t0 = cyc;
        rd();
        chk("R8 read while running", 32'(csr_rdata[4:3]), 32'h3);
        wr(8'h01);
        chk("R9 start while running", 32'(csr_rdata[4:3]), 32'h3);
        wait_end(t0, n);
        chk("R9 completion time kept", 32'(n), 32'(3 * ROWS));
        chk("R9 MS pass", 32'(csr_rdata[4:3]), 32'h1);

        // R5: raised reference fault on row 3
        @(negedge clk); f_hi_row = 3;
        wr(8'h01); t0 = cyc;
        wait_end(t0, n);
        chk("R5 stop latency", 32'(n), 32'(3 * 3 + 2));
        chk("R5 MS fail", 32'(csr_rdata[4:3]), 32'h2);
        chk("R5 MM high", 32'(csr_rdata[5]), 32'h1);
        chk("R5 arr_en low", 32'(arr_en), 32'h0);
        // R7, R11: read clears MS, MM kept
        rd();
        chk("R7 MS cleared after fail", 32'(csr_rdata[4:3]), 32'h0);
        chk("R11 MM kept after read", 32'(csr_rdata[5]), 32'h1);
        repeat (4) @(negedge clk);
        chk("R11 MM kept idle", 32'(csr_rdata[5]), 32'h1);

        // R10: illegal writes
        @(negedge clk); f_hi_row = -1;
        wr(8'h03);
        chk("R10 bit1 set no start", 32'(csr_rdata[4:0]), 32'h0);
        wr(8'h05);
        chk("R10 bit2 set no start", 32'(csr_rdata[4:0]), 32'h0);

        // R11: start clears MM; R6 lowered fault on last row
        @(negedge clk); f_lo_row = ROWS - 1;
        wr(8'h01); t0 = cyc;
        chk("R11 MM cleared on start", 32'(csr_rdata[5]), 32'h0);
        wait_end(t0, n);
        chk("R6 stop latency", 32'(n), 32'(3 * ROWS));
        chk("R6 MS fail", 32'(csr_rdata[4:3]), 32'h2);
        chk("R6 MM low", 32'(csr_rdata[5]), 32'h0);

        // R6: lowered fault on row 0
        @(negedge clk); f_lo_row = 0;
        wr(8'h01); t0 = cyc;
        wait_end(t0, n);
        chk("R6 row0 stop latency", 32'(n), 32'(3));
        chk("R6 row0 MS fail", 32'(csr_rdata[5:3]), 32'h2);

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule